// File: doc/BRIEF.md
# Column-Associative Cache Controller

This block is an 8 KiB data cache with 16-byte lines. It is built as two direct-mapped ways of 4 KiB each. The two ways are not searched together. Each lookup checks way 0 first. Way 1 is checked in the following cycle, and only when way 0 has no match. This keeps the compare path as short as in a direct-mapped cache, while conflicting lines still get a second place to live.

A hit in the second way exchanges the two lines of that set, so the most recently used line answers quickly next time. On a miss in both ways, the line is fetched from the next-level memory and written into way 0. The line that was in way 0 moves down to way 1, and the line that was in way 1 is dropped.

Loads and stores arrive through a valid/ready request port. Every store goes through to memory. A store that misses first fetches its line, so writes allocate. Each response carries one of three status flags (way-0 hit, way-1 hit, miss), which lets a user count the outcomes.

Top module: `cac_cache`

## Requirements
- R1: After reset every line is invalid, `req_ready` is high, and `resp_valid` and `mem_req_valid` are low. The first access to any address is reported as a miss.
- R2: Address bits 31:12 are the tag, bits 11:4 select the set, and bits 3:2 select the 32-bit word within the line (word w is line bits 32w+31:32w). A load returns that word as memory holds it.
- R3: Way 0 is always checked first. A load that hits in way 0 raises `resp_valid` with `resp_hit_way0` in the first cycle after the request is accepted.
- R4: Way 1 is checked only in the cycle after a way-0 miss. A load that hits there raises `resp_valid` with `resp_hit_way1` in the second cycle after acceptance.
- R5: A way-1 hit exchanges the two lines of the set. The hit line then answers from way 0, and the former way-0 line answers from way 1.
- R6: A miss in both ways issues one memory read at the line address (low four bits zero) in the third cycle after acceptance. A load miss responds with `resp_miss` in the cycle that `mem_rsp_valid` is sampled high, returning the word from the delivered line. A hit issues no read.
- R7: A refill writes the new line into way 0 and moves the old way-0 line into way 1. The line that was in way 1 is discarded, so an access to it then misses.
- R8: Every store issues exactly one memory write with the full request address and data. The store response comes in the cycle the write is accepted.
- R9: A store miss fetches the line, merges the store word into it and installs it in way 0. A following load to that word hits way 0 and returns the stored value.
- R10: While `resp_valid` is high, exactly one of the three status flags is high. While it is low, all three flags are low.
- R11: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays valid and its address and direction do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| req_valid | input | 1 | access request present |
| req_ready | output | 1 | controller idle and accepting |
| req_write | input | 1 | 1 for store, 0 for load |
| req_addr | input | 32 | byte address of the access |
| req_wdata | input | 32 | store data |
| resp_valid | output | 1 | access complete this cycle |
| resp_rdata | output | 32 | load data (zero for stores) |
| resp_hit_way0 | output | 1 | access found its line in way 0 |
| resp_hit_way1 | output | 1 | access found its line in way 1 |
| resp_miss | output | 1 | access missed both ways |
| mem_req_valid | output | 1 | next-level request present |
| mem_req_ready | input | 1 | next level takes the request |
| mem_req_write | output | 1 | 1 for word write, 0 for line read |
| mem_req_addr | output | 32 | request address |
| mem_req_wdata | output | 32 | write data |
| mem_rsp_valid | input | 1 | refill line delivered |
| mem_rsp_line | input | 128 | refill line, word 0 in the low bits |

## Verification
The bench goes after the conflict patterns of a single set.

Three tags compete for one set, and the bench checks the following:
- A design that skipped the exchange would keep reporting way-1 hits for a line that was just used.
- A design that dropped the wrong line on refill would hit where a miss is due.

It also checks probe latency, because a design that looked up way 1 in parallel or too late would answer a cycle early or late. Store misses are followed by loads, which catches a merge into the wrong word or a missed allocation. Refill and write requests are held off by the next level, to check that the request stays stable. A long address sweep then compares every outcome against a model of the two ways.

// File: rtl/cac_pkg.sv
package cac_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_P0,
    ST_P1,
    ST_FREQ,
    ST_FWAIT,
    ST_WT
  } cac_state_e;

  typedef enum logic [1:0] {
    K_HIT0,
    K_HIT1,
    K_MISS
  } cac_kind_e;

endpackage

// File: rtl/cac_way_store.sv
module cac_way_store #(
  parameter int SETS   = 256,
  parameter int IDX_W  = 8,
  parameter int TAG_W  = 20,
  parameter int LINE_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  idx,
  input  logic              wr_en,
  input  logic              wr_valid,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [LINE_W-1:0] wr_line,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [LINE_W-1:0] rd_line
);

  logic [SETS-1:0]   vbits;
  logic [TAG_W-1:0]  tags  [SETS];
  logic [LINE_W-1:0] lines [SETS];

  // valid bits are the only state that needs a reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vbits <= '0;
    end else if (wr_en) begin
      vbits[idx] <= wr_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tags[idx]  <= wr_tag;
      lines[idx] <= wr_line;
    end
  end

  assign rd_valid = vbits[idx];
  assign rd_tag   = tags[idx];
  assign rd_line  = lines[idx];

endmodule

// File: rtl/cac_tag_cmp.sv
module cac_tag_cmp #(
  parameter int TAG_W = 20
) (
  input  logic             valid,
  input  logic [TAG_W-1:0] stored,
  input  logic [TAG_W-1:0] lookup,
  output logic             hit
);

  assign hit = valid && (stored == lookup);

endmodule

// File: rtl/cac_seq.sv
module cac_seq
  import cac_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int OFF_W  = 4,
  parameter int IDX_W  = 8,
  parameter int LINE_W = 128
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                req_valid,
  output logic                                req_ready,
  input  logic                                req_write,
  input  logic [ADDR_W-1:0]                   req_addr,
  input  logic [DATA_W-1:0]                   req_wdata,
  output logic                                resp_valid,
  output logic [DATA_W-1:0]                   resp_rdata,
  output logic                                resp_hit_way0,
  output logic                                resp_hit_way1,
  output logic                                resp_miss,
  output logic                                mem_req_valid,
  input  logic                                mem_req_ready,
  output logic                                mem_req_write,
  output logic [ADDR_W-1:0]                   mem_req_addr,
  output logic [DATA_W-1:0]                   mem_req_wdata,
  input  logic                                mem_rsp_valid,
  input  logic [LINE_W-1:0]                   mem_rsp_line,
  output logic [IDX_W-1:0]                    probe_idx,
  output logic [ADDR_W-IDX_W-OFF_W-1:0]       probe_tag,
  input  logic [1:0]                          way_hit,
  input  logic [1:0]                          rd_valid,
  input  logic [1:0][ADDR_W-IDX_W-OFF_W-1:0]  rd_tag,
  input  logic [1:0][LINE_W-1:0]              rd_line,
  output logic [1:0]                          wr_en,
  output logic [1:0]                          wr_valid,
  output logic [1:0][ADDR_W-IDX_W-OFF_W-1:0]  wr_tag,
  output logic [1:0][LINE_W-1:0]              wr_line,
  output logic                                ev_swap,
  output logic                                ev_fill
);

  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int WORDS  = LINE_W / DATA_W;
  localparam int WSEL_W = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam int BOFF_W = OFF_W - $clog2(WORDS);

  // ---- arithmetic kept in functions so the bench can restate it
  function automatic logic [LINE_W-1:0] put_word(input logic [LINE_W-1:0] line,
                                                 input logic [WSEL_W-1:0] sel,
                                                 input logic [DATA_W-1:0] w);
    logic [LINE_W-1:0] r;
    r = line;
    r[sel*DATA_W +: DATA_W] = w;
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] get_word(input logic [LINE_W-1:0] line,
                                                 input logic [WSEL_W-1:0] sel);
    return line[sel*DATA_W +: DATA_W];
  endfunction

  function automatic logic [ADDR_W-1:0] line_base(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  endfunction

  cac_state_e          state, state_n;
  cac_kind_e           kind_q, kind_n;
  logic                wr_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [DATA_W-1:0]   wdata_q;
  logic [WSEL_W-1:0]   wsel;

  logic ev_hit0, ev_hit1, ev_miss;

  assign probe_idx = addr_q[OFF_W +: IDX_W];
  assign probe_tag = addr_q[ADDR_W-1 -: TAG_W];
  assign wsel      = addr_q[BOFF_W +: WSEL_W];

  assign ev_hit0 = (state == ST_P0) && way_hit[0];
  assign ev_hit1 = (state == ST_P1) && way_hit[1];
  assign ev_miss = (state == ST_P1) && !way_hit[1];
  assign ev_swap = ev_hit1;
  assign ev_fill = (state == ST_FWAIT) && mem_rsp_valid;

  // ---- sequencing
  always_comb begin
    state_n = state;
    kind_n  = kind_q;
    unique case (state)
      ST_IDLE:  if (req_valid) state_n = ST_P0;
      ST_P0: begin
        if (way_hit[0]) begin
          kind_n  = K_HIT0;
          state_n = wr_q ? ST_WT : ST_IDLE;
        end else begin
          state_n = ST_P1;
        end
      end
      ST_P1: begin
        if (way_hit[1]) begin
          kind_n  = K_HIT1;
          state_n = wr_q ? ST_WT : ST_IDLE;
        end else begin
          kind_n  = K_MISS;
          state_n = ST_FREQ;
        end
      end
      ST_FREQ:  if (mem_req_ready) state_n = ST_FWAIT;
      ST_FWAIT: if (mem_rsp_valid) state_n = wr_q ? ST_WT : ST_IDLE;
      ST_WT:    if (mem_req_ready) state_n = ST_IDLE;
      default:  state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      kind_q  <= K_HIT0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      state  <= state_n;
      kind_q <= kind_n;
      if (state == ST_IDLE && req_valid) begin
        wr_q    <= req_write;
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
    end
  end

  // ---- way updates: store merge, exchange, refill with demotion
  always_comb begin
    wr_en    = '0;
    wr_valid = '0;
    wr_tag   = '0;
    wr_line  = '0;
    if (ev_hit0 && wr_q) begin
      wr_en[0]    = 1'b1;
      wr_valid[0] = 1'b1;
      wr_tag[0]   = rd_tag[0];
      wr_line[0]  = put_word(rd_line[0], wsel, wdata_q);
    end else if (ev_swap) begin
      wr_en       = 2'b11;
      wr_valid[0] = 1'b1;
      wr_tag[0]   = rd_tag[1];
      wr_line[0]  = wr_q ? put_word(rd_line[1], wsel, wdata_q) : rd_line[1];
      wr_valid[1] = rd_valid[0];
      wr_tag[1]   = rd_tag[0];
      wr_line[1]  = rd_line[0];
    end else if (ev_fill) begin
      wr_en       = 2'b11;
      wr_valid[0] = 1'b1;
      wr_tag[0]   = probe_tag;
      wr_line[0]  = wr_q ? put_word(mem_rsp_line, wsel, wdata_q) : mem_rsp_line;
      wr_valid[1] = rd_valid[0];
      wr_tag[1]   = rd_tag[0];
      wr_line[1]  = rd_line[0];
    end
  end

  // ---- responses
  logic load_done0, load_done1, load_done_m, store_done;
  assign load_done0  = ev_hit0 && !wr_q;
  assign load_done1  = ev_hit1 && !wr_q;
  assign load_done_m = ev_fill && !wr_q;
  assign store_done  = (state == ST_WT) && mem_req_ready;

  assign req_ready  = (state == ST_IDLE);
  assign resp_valid = load_done0 || load_done1 || load_done_m || store_done;

  always_comb begin
    resp_rdata = '0;
    if (load_done0)       resp_rdata = get_word(rd_line[0], wsel);
    else if (load_done1)  resp_rdata = get_word(rd_line[1], wsel);
    else if (load_done_m) resp_rdata = get_word(mem_rsp_line, wsel);
  end

  assign resp_hit_way0 = load_done0  || (store_done && kind_q == K_HIT0);
  assign resp_hit_way1 = load_done1  || (store_done && kind_q == K_HIT1);
  assign resp_miss     = load_done_m || (store_done && kind_q == K_MISS);

  // ---- next-level requests
  assign mem_req_valid = (state == ST_FREQ) || (state == ST_WT);
  assign mem_req_write = (state == ST_WT);
  assign mem_req_addr  = (state == ST_FREQ) ? line_base(addr_q) : addr_q;
  assign mem_req_wdata = wdata_q;

  // ---- assertions
  p_way1_after_way0_miss_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_P1) |-> ($past(state) == ST_P0 && !$past(way_hit[0])));

  p_one_status_r10: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $onehot({resp_hit_way0, resp_hit_way1, resp_miss}));

  p_quiet_status_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !resp_valid |-> !(resp_hit_way0 || resp_hit_way1 || resp_miss));

  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));

  p_line_aligned_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_write) |-> (mem_req_addr[OFF_W-1:0] == '0));

  p_miss_goes_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_miss |=> (mem_req_valid && !mem_req_write));

endmodule

// File: rtl/cac_cache.sv
module cac_cache #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_BYTES = 16,
  parameter int WAY_BYTES  = 4096
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [DATA_W-1:0]       req_wdata,
  output logic                    resp_valid,
  output logic [DATA_W-1:0]       resp_rdata,
  output logic                    resp_hit_way0,
  output logic                    resp_hit_way1,
  output logic                    resp_miss,
  output logic                    mem_req_valid,
  input  logic                    mem_req_ready,
  output logic                    mem_req_write,
  output logic [ADDR_W-1:0]       mem_req_addr,
  output logic [DATA_W-1:0]       mem_req_wdata,
  input  logic                    mem_rsp_valid,
  input  logic [LINE_BYTES*8-1:0] mem_rsp_line
);

  localparam int NWAYS  = 2;
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int SETS   = WAY_BYTES / LINE_BYTES;
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int LINE_W = LINE_BYTES * 8;

  logic [IDX_W-1:0]             probe_idx;
  logic [TAG_W-1:0]             probe_tag;
  logic [NWAYS-1:0]             way_hit;
  logic [NWAYS-1:0]             rd_valid;
  logic [NWAYS-1:0][TAG_W-1:0]  rd_tag;
  logic [NWAYS-1:0][LINE_W-1:0] rd_line;
  logic [NWAYS-1:0]             wr_en;
  logic [NWAYS-1:0]             wr_valid;
  logic [NWAYS-1:0][TAG_W-1:0]  wr_tag;
  logic [NWAYS-1:0][LINE_W-1:0] wr_line;
  logic                         ev_swap;
  logic                         ev_fill;

  for (genvar g = 0; g < NWAYS; g++) begin : g_way
    cac_way_store #(
      .SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W), .LINE_W(LINE_W)
    ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .idx      (probe_idx),
      .wr_en    (wr_en[g]),
      .wr_valid (wr_valid[g]),
      .wr_tag   (wr_tag[g]),
      .wr_line  (wr_line[g]),
      .rd_valid (rd_valid[g]),
      .rd_tag   (rd_tag[g]),
      .rd_line  (rd_line[g])
    );

    cac_tag_cmp #(.TAG_W(TAG_W)) u_cmp (
      .valid  (rd_valid[g]),
      .stored (rd_tag[g]),
      .lookup (probe_tag),
      .hit    (way_hit[g])
    );
  end

  cac_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .LINE_W(LINE_W)
  ) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_write     (req_write),
    .req_addr      (req_addr),
    .req_wdata     (req_wdata),
    .resp_valid    (resp_valid),
    .resp_rdata    (resp_rdata),
    .resp_hit_way0 (resp_hit_way0),
    .resp_hit_way1 (resp_hit_way1),
    .resp_miss     (resp_miss),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_line  (mem_rsp_line),
    .probe_idx     (probe_idx),
    .probe_tag     (probe_tag),
    .way_hit       (way_hit),
    .rd_valid      (rd_valid),
    .rd_tag        (rd_tag),
    .rd_line       (rd_line),
    .wr_en         (wr_en),
    .wr_valid      (wr_valid),
    .wr_tag        (wr_tag),
    .wr_line       (wr_line),
    .ev_swap       (ev_swap),
    .ev_fill       (ev_fill)
  );

  // the exchanged set reads back with its two tags crossed over
  p_swap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_swap |=> (rd_tag[0] == $past(rd_tag[1]) && rd_tag[1] == $past(rd_tag[0])
                 && rd_valid[0] && rd_valid[1] == $past(rd_valid[0])));

  // refill: new line on top, former way-0 line one step down
  p_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fill |=> (rd_valid[0] && rd_tag[0] == $past(probe_tag)
                 && rd_tag[1] == $past(rd_tag[0]) && rd_valid[1] == $past(rd_valid[0])));

endmodule

// File: tb/sim_cac_cache.sv
module sim_cac_cache;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         req_valid, req_ready, req_write;
  logic [31:0]  req_addr, req_wdata;
  logic         resp_valid, resp_hit_way0, resp_hit_way1, resp_miss;
  logic [31:0]  resp_rdata;
  logic         mem_req_valid, mem_req_ready, mem_req_write;
  logic [31:0]  mem_req_addr, mem_req_wdata;
  logic         mem_rsp_valid;
  logic [127:0] mem_rsp_line;

  always #5 clk = ~clk;

  cac_cache u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata),
    .resp_hit_way0(resp_hit_way0), .resp_hit_way1(resp_hit_way1), .resp_miss(resp_miss),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_line(mem_rsp_line)
  );

  int nchecks = 0;
  int nfail   = 0;
  bit done    = 0;

  // bench-side model of the two ways: valid and tag per set
  logic        mv0 [256];
  logic        mv1 [256];
  logic [19:0] mt0 [256];
  logic [19:0] mt1 [256];
  logic [31:0] ovl [logic [31:0]];

  // results of the last access
  bit          r_got, r_stable, r_quiet;
  int          r_kind, r_lat, r_nrd, r_nwr;
  logic [31:0] r_rdata, r_ra, r_wa, r_wd;

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    nchecks++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    logic [31:0] wa;
    wa = {a[31:2], 2'b00};
    if (ovl.exists(wa)) return ovl[wa];
    return (wa * 32'h9E37_79B1) ^ 32'h5A5A_1234;
  endfunction

  function automatic logic [127:0] mem_line(input logic [31:0] a);
    logic [127:0] l;
    for (int w = 0; w < 4; w++) l[32*w +: 32] = mem_word({a[31:4], w[1:0], 2'b00});
    return l;
  endfunction

  function automatic logic [31:0] mk(input logic [19:0] t, input int idx, input int w);
    return {t, idx[7:0], w[1:0], 2'b00};
  endfunction

  // drive one access and play the next-level memory until it responds
  task automatic access(input logic wr, input logic [31:0] a, input logic [31:0] d,
                        input int stall);
    int lat, cnt, rsp_cnt;
    bit pend;
    logic [31:0] paddr, rd_a;
    logic pwr;
    cnt = stall; rsp_cnt = -1; pend = 0; paddr = '0; pwr = 0; rd_a = '0;
    r_got = 0; r_stable = 1; r_quiet = 1; r_kind = 3; r_lat = 0;
    r_nrd = 0; r_nwr = 0; r_rdata = '0; r_ra = '0; r_wa = '0; r_wd = '0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!r_got && lat < 100) begin
      mem_req_ready = 1'b0;
      mem_rsp_valid = 1'b0;
      if (rsp_cnt == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_line  = mem_line(rd_a);
        rsp_cnt = -1;
      end else if (rsp_cnt > 0) begin
        rsp_cnt--;
      end
      if (mem_req_valid) begin
        if (pend && (mem_req_addr !== paddr || mem_req_write !== pwr)) r_stable = 0;
        pend = 1; paddr = mem_req_addr; pwr = mem_req_write;
        if (cnt > 0) begin
          cnt--;
        end else begin
          mem_req_ready = 1'b1;
          pend = 0;
          cnt = stall;
          if (mem_req_write) begin
            r_nwr++; r_wa = mem_req_addr; r_wd = mem_req_wdata;
          end else begin
            r_nrd++; r_ra = mem_req_addr; rd_a = mem_req_addr; rsp_cnt = 1;
          end
        end
      end
      #1;
      if (resp_valid) begin
        r_got = 1; r_lat = lat; r_rdata = resp_rdata;
        case ({resp_miss, resp_hit_way1, resp_hit_way0})
          3'b001:  r_kind = 0;
          3'b010:  r_kind = 1;
          3'b100:  r_kind = 2;
          default: r_kind = 3;
        endcase
      end else if (resp_hit_way0 || resp_hit_way1 || resp_miss) begin
        r_quiet = 0;
      end
      if (!r_got) begin
        @(negedge clk);
        lat++;
      end
    end
    @(negedge clk);
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
  endtask

  // one access with expectations from the model
  task automatic run(input logic wr, input logic [31:0] a, input logic [31:0] d,
                     input int stall, input string ctx);
    int ek, i, elat;
    logic [19:0] t;
    logic [31:0] ed;
    string kreq;
    i = int'(a[11:4]);
    t = a[31:12];
    ed = mem_word(a);
    if (mv0[i] && mt0[i] == t) begin
      ek = 0;
    end else if (mv1[i] && mt1[i] == t) begin
      ek = 1;
      mt1[i] = mt0[i]; mv1[i] = mv0[i];
      mt0[i] = t;      mv0[i] = 1'b1;
    end else begin
      ek = 2;
      mt1[i] = mt0[i]; mv1[i] = mv0[i];
      mt0[i] = t;      mv0[i] = 1'b1;
    end
    kreq = (ek == 0) ? "R3" : (ek == 1) ? "R4" : "R6";
    access(wr, a, d, stall);
    chk({ctx, " ", kreq, " status kind"}, r_kind, ek);
    chk({ctx, " R10 flags quiet without response"}, r_quiet, 1);
    chk({ctx, " R11 request held stable"}, r_stable, 1);
    chk({ctx, " R6 read count"}, r_nrd, (ek == 2) ? 1 : 0);
    if (ek == 2) chk({ctx, " R6 line address"}, r_ra, {a[31:4], 4'h0});
    if (!wr) begin
      elat = (ek == 0) ? 1 : (ek == 1) ? 2 : 5 + stall;
      chk({ctx, " ", kreq, " load latency"}, r_lat, elat);
      chk({ctx, " R2 load data"}, r_rdata, ed);
      chk({ctx, " R8 no write on load"}, r_nwr, 0);
    end else begin
      chk({ctx, " R8 write count"}, r_nwr, 1);
      chk({ctx, " R8 write address"}, r_wa, a);
      chk({ctx, " R8 write data"}, r_wd, d);
      ovl[{a[31:2], 2'b00}] = d;
    end
  endtask

  localparam logic [19:0] TA = 20'h00010;
  localparam logic [19:0] TB = 20'h00020;
  localparam logic [19:0] TC = 20'h00030;

  initial begin
    for (int i = 0; i < 256; i++) begin
      mv0[i] = 1'b0; mv1[i] = 1'b0; mt0[i] = '0; mt1[i] = '0;
    end
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_line = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", req_ready, 1);
    chk("R1 no response after reset", resp_valid, 0);
    chk("R1 no memory request after reset", mem_req_valid, 0);

    // set 5: three tags competing
    run(0, mk(TA, 5, 1), 0, 0, "R1 cold miss");
    run(0, mk(TA, 5, 2), 0, 0, "R3 fast hit");
    run(0, mk(TB, 5, 0), 0, 0, "R7 demote");
    run(0, mk(TA, 5, 3), 0, 0, "R4 second-way hit");
    run(0, mk(TA, 5, 0), 0, 0, "R5 swapped in");
    run(0, mk(TB, 5, 1), 0, 0, "R5 swapped out");
    run(0, mk(TC, 5, 2), 0, 0, "R7 refill");
    run(0, mk(TA, 5, 0), 0, 0, "R7 discarded line");
    // stores: allocate, hit in way 1, hit in way 0
    run(1, mk(TA, 255, 3), 32'hCAFE_0001, 0, "R9 store miss");
    run(0, mk(TA, 255, 3), 0, 0, "R9 allocated load");
    run(1, mk(TC, 5, 1), 32'hBEEF_0002, 0, "R8 store way1");
    run(0, mk(TC, 5, 1), 0, 0, "R8 merged way0");
    run(1, mk(TC, 5, 1), 32'h1234_5678, 0, "R8 store way0");
    run(0, mk(TC, 5, 1), 0, 0, "R8 reread");
    // next level holding off its ready
    run(0, mk(TB, 0, 0), 0, 3, "R11 stalled refill");
    run(1, mk(TC, 0, 2), 32'h0BAD_F00D, 2, "R11 stalled store");
    run(0, mk(TC, 0, 2), 0, 1, "R11 reload");
    // sweep across sets, tags and words
    for (int k = 0; k < 600; k++) begin
      int idx, ts, w;
      logic [19:0] t;
      idx = (k * 13) % 32 + ((k % 7 == 0) ? 224 : 0);
      ts  = (k * 7 + k / 3) % 4;
      w   = (k / 2) % 4;
      t   = 20'h00100 + ts[19:0];
      run((k % 4) == 1, mk(t, idx, w), 32'hA000_0000 + k, 0, "R2 sweep");
    end
    done = 1;
    $display("%0d/%0d checks passed", nchecks - nfail, nchecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchecks++;
      nfail++;
      $display("FAIL watchdog R10 actual=running expected=finished");
      $display("%0d/%0d checks passed", nchecks - nfail, nchecks);
      $finish;
    end
  end

endmodule